// File: doc/BRIEF.md
# TDM Frame Assembler with PN Sync Word

This block turns a set of parallel channel words into one continuous serial bit stream, one bit per clock. Each frame opens with a 15-chip synchronisation word. A four-stage linear feedback shift register produces this word on the fly, and it is a maximal-length pseudo-noise sequence. Because such a sequence matches itself fully at zero shift and only weakly at any other shift, a receiver can find the frame boundary with a correlator. After the sync word comes one information word per channel, in ascending channel order, each sent most significant bit first. The next frame follows at once, with no idle clocks between frames.

The upstream logic offers a new set of channel words by raising a load request. The block accepts the set only during the last sync chip and confirms this with a one-cycle acknowledge. The words are sent in the data part of that same frame. A request in any other cycle is ignored, and the block keeps sending the set it already holds. A one-cycle marker goes high on the first chip of every frame.

Top module: `tdm_frame_builder`

## Requirements
- R1: A frame is 15 sync chips followed by N_CH words of WORD_W bits each, in the order channel 0, 1, ..., N_CH-1. Channel c is taken from ch_data[c*WORD_W +: WORD_W] and sent MSB first. A frame lasts 15 + N_CH*WORD_W clocks, and frames follow each other with no gap.
- R2: The sync chips are 0,0,0,1,0,0,1,1,0,1,0,1,1,1,1 in the order sent. They come from a 4-bit LFSR with polynomial x^4 + x^3 + 1, seeded with 4'b0001 and shifted left with feedback bit s[3]^s[2]; the chip sent is s[3]. The LFSR is reseeded for every frame, so every frame carries the same word, and its state is never zero.
- R3: frame_start is high for exactly one clock, on the first sync chip of each frame. It therefore repeats every 15 + N_CH*WORD_W clocks.
- R4: When ld_req is high during the last sync chip (chip index 14), ld_take is high in that same cycle and all channel words are latched from ch_data. The latched words are sent in the data part of the same frame.
- R5: ld_req in any other cycle is ignored and ld_take stays low. The previously latched words are sent again unchanged.
- R6: While rst is high at a rising edge, the block goes to the first sync chip: frame_start is 1, ser_out is 0 and the LFSR holds its seed. All latched channel words are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_req | input | 1 | Request to latch a new set of channel words |
| ch_data | input | N_CH*WORD_W | Channel words; channel c at bits [c*WORD_W +: WORD_W] |
| ld_take | output | 1 | High in the cycle in which ch_data is latched |
| ser_out | output | 1 | Serial TDM stream |
| frame_start | output | 1 | High on the first sync chip of each frame |

## Verification
The bench builds the block with N_CH = 3 and WORD_W = 5, which gives a frame of 30 clocks. Neither count is a power of two, so the channel counter has to wrap at 2 and the bit counter has to start at 4; an error in how either wraps shows up as a shifted or repeated data bit. The short frame also fits many frames into a short run: repeated sync words, load attempts in several wrong cycles, and a reset in the middle of a frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  localparam int PN_LEN = 15;
  localparam int PN_STAGES = 4;
  localparam logic [PN_STAGES-1:0] PN_SEED = 4'b0001;

  typedef enum logic {PH_SYNC, PH_DATA} phase_t;

  // One shift of the x^4 + x^3 + 1 register: left shift, feedback of the top two stages
  function automatic logic [PN_STAGES-1:0] pn_step(input logic [PN_STAGES-1:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  function automatic int frame_len(input int n_ch, input int word_w);
    return PN_LEN + n_ch * word_w;
  endfunction

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/tdm_pn_gen.sv
module tdm_pn_gen
  import tdm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 restart,
  output logic                 chip,
  output logic [PN_STAGES-1:0] pn_state
);

  logic [PN_STAGES-1:0] pn_q;

  always_ff @(posedge clk) begin
    if (rst || restart) pn_q <= PN_SEED;
    else if (adv)       pn_q <= pn_step(pn_q);
  end

  assign chip     = pn_q[PN_STAGES-1];
  assign pn_state = pn_q;

  p_pn_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    pn_q != '0);

  p_pn_reseed_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> pn_q == PN_SEED);

endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq
  import tdm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int WORD_W = 8,
  localparam int CHIP_W = idx_width(PN_LEN),
  localparam int CH_W   = idx_width(N_CH),
  localparam int BIT_W  = idx_width(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  output phase_t           phase,
  output logic [CH_W-1:0]  ch_idx,
  output logic [BIT_W-1:0] bit_idx,
  output logic             sync_adv,
  output logic             sync_last,
  output logic             frame_start
);

  phase_t              phase_q;
  logic [CHIP_W-1:0]   chip_q;
  logic [CH_W-1:0]     ch_q;
  logic [BIT_W-1:0]    bit_q;
  logic                word_last;
  logic                data_last;

  assign sync_last   = (phase_q == PH_SYNC) && (chip_q == CHIP_W'(PN_LEN - 1));
  assign sync_adv    = (phase_q == PH_SYNC) && !sync_last;
  assign frame_start = (phase_q == PH_SYNC) && (chip_q == '0);
  assign word_last   = (phase_q == PH_DATA) && (bit_q == '0);
  assign data_last   = word_last && (ch_q == CH_W'(N_CH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_SYNC;
      chip_q  <= '0;
      ch_q    <= '0;
      bit_q   <= BIT_W'(WORD_W - 1);
    end else begin
      case (phase_q)
        PH_SYNC: begin
          if (sync_last) begin
            phase_q <= PH_DATA;
            chip_q  <= '0;
            ch_q    <= '0;
            bit_q   <= BIT_W'(WORD_W - 1);
          end else begin
            chip_q <= chip_q + CHIP_W'(1);
          end
        end
        default: begin
          if (word_last) begin
            bit_q <= BIT_W'(WORD_W - 1);
            if (data_last) begin
              phase_q <= PH_SYNC;
              ch_q    <= '0;
            end else begin
              ch_q <= ch_q + CH_W'(1);
            end
          end else begin
            bit_q <= bit_q - BIT_W'(1);
          end
        end
      endcase
    end
  end

  assign phase   = phase_q;
  assign ch_idx  = ch_q;
  assign bit_idx = bit_q;

  p_sync_to_data_r1: assert property (@(posedge clk) disable iff (rst)
    sync_last |=> (phase_q == PH_DATA) && (ch_q == '0) && (bit_q == BIT_W'(WORD_W - 1)));

  p_data_to_sync_r1: assert property (@(posedge clk) disable iff (rst)
    data_last |=> frame_start);

  p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

endmodule

// File: rtl/tdm_word_bank.sv
module tdm_word_bank
  import tdm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int WORD_W = 8,
  localparam int NW    = N_CH * WORD_W,
  localparam int CH_W  = idx_width(N_CH),
  localparam int BIT_W = idx_width(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [NW-1:0]    wr_data,
  input  logic [CH_W-1:0]  sel_ch,
  input  logic [BIT_W-1:0] sel_bit,
  output logic             bit_out
);

  logic [WORD_W-1:0] word_q [N_CH];
  logic [NW-1:0]     bank_flat;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)         word_q[g] <= '0;
      else if (cap_en) word_q[g] <= wr_data[g*WORD_W +: WORD_W];
    end
    assign bank_flat[g*WORD_W +: WORD_W] = word_q[g];
  end

  assign bit_out = word_q[sel_ch][sel_bit];

  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> bank_flat == $past(wr_data));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> bank_flat == $past(bank_flat));

endmodule

// File: rtl/tdm_frame_builder.sv
module tdm_frame_builder
  import tdm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int WORD_W = 8,
  localparam int NW        = N_CH * WORD_W,
  localparam int CH_W      = idx_width(N_CH),
  localparam int BIT_W     = idx_width(WORD_W),
  localparam int FRAME_LEN = frame_len(N_CH, WORD_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_req,
  input  logic [NW-1:0] ch_data,
  output logic          ld_take,
  output logic          ser_out,
  output logic          frame_start
);

  phase_t               phase;
  logic [CH_W-1:0]      ch_idx;
  logic [BIT_W-1:0]     bit_idx;
  logic                 sync_adv;
  logic                 sync_last;
  logic                 pn_chip;
  logic [PN_STAGES-1:0] pn_state;
  logic                 data_bit;

  tdm_frame_seq #(.N_CH(N_CH), .WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase),
    .ch_idx      (ch_idx),
    .bit_idx     (bit_idx),
    .sync_adv    (sync_adv),
    .sync_last   (sync_last),
    .frame_start (frame_start)
  );

  tdm_pn_gen u_pn (
    .clk      (clk),
    .rst      (rst),
    .adv      (sync_adv),
    .restart  (sync_last),
    .chip     (pn_chip),
    .pn_state (pn_state)
  );

  assign ld_take = ld_req && sync_last;

  tdm_word_bank #(.N_CH(N_CH), .WORD_W(WORD_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (ld_take),
    .wr_data (ch_data),
    .sel_ch  (ch_idx),
    .sel_bit (bit_idx),
    .bit_out (data_bit)
  );

  assign ser_out = (phase == PH_SYNC) ? pn_chip : data_bit;

  // Cycle distance between frame markers, kept for the period check
  int unsigned gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (frame_start) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  p_frame_period_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_start && seen_q) |-> (gap_q == FRAME_LEN - 1));

  p_reset_home_r6: assert property (@(posedge clk)
    rst |=> frame_start && (pn_state == PN_SEED));

endmodule

// File: tb/test_tdm_frame_builder.sv
module test_tdm_frame_builder;
  import tdm_pkg::*;

  localparam int CLK_P  = 10;
  localparam int N_CH   = 3;
  localparam int WORD_W = 5;
  localparam int NW     = N_CH * WORD_W;
  localparam int FL     = PN_LEN + N_CH * WORD_W;

  typedef struct {
    logic  fs;
    logic  d;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_req = 1'b0;
  logic [NW-1:0] ch_data = '0;
  logic          ld_take;
  logic          ser_out;
  logic          frame_start;

  int   checks = 0;
  int   fails  = 0;
  logic mon_on = 1'b0;
  logic done   = 1'b0;
  exp_t sb_q[$];
  logic [NW-1:0] model = '0;
  logic [PN_LEN-1:0] pn_ref;

  always #(CLK_P/2) clk = ~clk;

  tdm_frame_builder #(.N_CH(N_CH), .WORD_W(WORD_W)) i_tdm_frame_builder (
    .clk(clk), .rst(rst), .ld_req(ld_req), .ch_data(ch_data),
    .ld_take(ld_take), .ser_out(ser_out), .frame_start(frame_start)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Sync chips from the bit recurrence c[n+4] = c[n+1] ^ c[n], first four 0,0,0,1
  function automatic logic [PN_LEN-1:0] make_pn();
    logic [PN_LEN-1:0] c;
    c = '0;
    c[3] = 1'b1;
    for (int n = 4; n < PN_LEN; n++) c[n] = c[n-3] ^ c[n-4];
    return c;
  endfunction

  task automatic push_frame(input logic [NW-1:0] words, input string tag);
    for (int i = 0; i < PN_LEN; i++) sb_q.push_back('{fs: (i == 0), d: pn_ref[i], req: "R2"});
    for (int c = 0; c < N_CH; c++)
      for (int b = WORD_W - 1; b >= 0; b--)
        sb_q.push_back('{fs: 1'b0, d: words[c*WORD_W + b], req: tag});
  endtask

  // Entered 1 time unit after the edge that starts chip 0 of a frame
  task automatic run_frame(input int req_pos, input logic spam, input logic [NW-1:0] cap,
                           input logic [NW-1:0] junk, input string tag);
    if (req_pos == PN_LEN - 1) model = cap;
    push_frame(model, tag);
    for (int pos = 0; pos < FL; pos++) begin
      ld_req  = (pos == req_pos) || (spam && pos >= PN_LEN);
      ch_data = (pos == PN_LEN - 1) ? cap : junk;
      #1;
      if (pos == PN_LEN - 1)
        check(ld_take == ld_req, "R4", "ld_take at last chip", ld_take, ld_req);
      else
        check(ld_take == 1'b0, "R5", "ld_take outside last chip", ld_take, 0);
      @(posedge clk); #1;
    end
    ld_req = 1'b0;
  endtask

  task automatic do_reset();
    mon_on = 1'b0;
    sb_q.delete();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(frame_start == 1'b1, "R6", "frame_start in reset", frame_start, 1);
    check(ser_out == 1'b0, "R6", "ser_out in reset", ser_out, 0);
    rst    = 1'b0;
    model  = '0;
    mon_on = 1'b1;
  endtask

  // Scoreboard monitor: one expected item per clock, compared at the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R1", "output with empty scoreboard", 0, 1);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(frame_start == e.fs, "R3", "frame_start", frame_start, e.fs);
        check(ser_out == e.d, e.req, "ser_out", ser_out, e.d);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    pn_ref = make_pn();
    do_reset();
    // R4: capture on the last chip, sent in the same frame
    run_frame(PN_LEN - 1, 1'b0, NW'(64'h5A3C), NW'(64'h1111), "R4");
    // R5: request on an early sync chip is ignored
    run_frame(3, 1'b0, NW'(64'h7FFF), NW'(64'h2222), "R5");
    // R5: requests throughout the data part are ignored
    run_frame(-1, 1'b1, NW'(64'h0F0F), NW'(64'h4B6D), "R5");
    // R4 with requests also in the data part; new set wins only at chip 14
    run_frame(PN_LEN - 1, 1'b1, NW'(64'h6A91), NW'(64'h0000), "R4");
    // R1: boundary patterns, all ones then alternating
    run_frame(PN_LEN - 1, 1'b0, {NW{1'b1}}, NW'(64'h1234), "R1");
    run_frame(PN_LEN - 1, 1'b0, NW'(64'h5555), NW'(64'h0000), "R1");
    run_frame(0, 1'b0, NW'(64'h2AAA), NW'(64'h3333), "R5");
    // R6: reset in the middle of a frame after loading new words
    model   = NW'(64'h7C3E);
    mon_on  = 1'b0;
    sb_q.delete();
    ld_req  = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    do_reset();
    run_frame(-1, 1'b0, NW'(64'h7FFF), NW'(64'h7FFF), "R6");
    run_frame(PN_LEN - 1, 1'b0, NW'(64'h4321), NW'(64'h0000), "R4");
    mon_on = 1'b0;
    check(sb_q.size() == 0, "R1", "scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule